// File: doc/BRIEF.md
# Narrow-to-Wide Memory Port Up-Converter

This block connects a narrow user memory port to a wider memory port whose data width is a whole power-of-two multiple of the user width. Each side has three valid/ready channels: commands, write data and read data. A command carries a write-enable bit, an address and an end-of-sequence flag. The narrow address selects one sub-word. The wide address is the narrow address shifted right by log2 of the width ratio. The low bits of the narrow address pick the lane inside the wide word, and lane 0 is the least significant sub-word.

Narrow writes that fall in the same wide word are merged into one wide write. Its byte-enable vector covers only the lanes that were written, so lanes that were skipped keep their memory contents. Narrow reads that fall in the same wide word become one wide read. The lane of every narrow read is kept in a small queue, which is used to return the matching sub-word of each returned wide word, one narrow response per narrow read, in command order. A group is sent out when one of four things happens: it holds a full run of ratio commands, a command arrives for a different wide address, a command of the other type arrives, or a command carries the end flag. A width ratio that is not a power-of-two integer stops elaboration.

Top module: `mem_upsizer`

## Requirements
- R1: With equal widths (ratio 1), every channel passes straight through combinationally, with ready flowing back and no added cycle.
- R2: Packing is little-endian. The narrow address bits below log2(ratio) select the lane, with lane k at data bits [k*NW +: NW]. The wide address is the narrow address shifted right by log2(ratio).
- R3: A full run of ratio narrow writes to one wide address produces exactly one wide write, with all byte enables set.
- R4: A narrow command with the end flag set sends the group it closes on the next cycle. Wide byte enables are set only for the lanes that were written, and the bytes of unwritten lanes stay unchanged in memory.
- R5: A narrow command whose wide address differs from the open group makes the open group go out first. The new command is accepted only after that.
- R6: A narrow command of the other type (read versus write) makes the open group go out first.
- R7: Non-consecutive writes set only their own lanes' byte enables. With ratio 4, writes to lanes 0, 2 and 3 give byte-enable value 4'b1101.
- R8: Narrow reads in one wide group produce one wide read. Each narrow read gets exactly one narrow response carrying its own lane, in command order.
- R9: Read responses are correct when the wide port answers one cycle after the command or two cycles after it, and for sequences that start at an unaligned narrow address.
- R10: A stalled wide command or wide write beat holds its address, type, data and byte enables until accepted. Backpressure on any channel loses and duplicates no beat.
- R11: A narrow write is accepted only when its command and its write data are both valid. Command ready and write-data ready rise together.
- R12: While the read-lane queue holds RDQ entries that have not been answered, no further narrow read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| n_cmd_valid | input | 1 | Narrow command valid |
| n_cmd_ready | output | 1 | Narrow command ready |
| n_cmd_we | input | 1 | Narrow command is a write |
| n_cmd_addr | input | AW | Narrow sub-word address |
| n_cmd_last | input | 1 | End of sequence; sends the open group |
| n_wr_valid | input | 1 | Narrow write data valid |
| n_wr_ready | output | 1 | Narrow write data ready |
| n_wr_data | input | NW | Narrow write data |
| n_wr_be | input | NW/8 | Narrow byte enables |
| n_rd_valid | output | 1 | Narrow read response valid |
| n_rd_ready | input | 1 | Narrow read response ready |
| n_rd_data | output | NW | Narrow read response data |
| w_cmd_valid | output | 1 | Wide command valid |
| w_cmd_ready | input | 1 | Wide command ready |
| w_cmd_we | output | 1 | Wide command is a write |
| w_cmd_addr | output | AW-log2(WW/NW) | Wide word address |
| w_wr_valid | output | 1 | Wide write data valid |
| w_wr_ready | input | 1 | Wide write data ready |
| w_wr_data | output | WW | Wide write data |
| w_wr_be | output | WW/8 | Wide byte enables |
| w_rd_valid | input | 1 | Wide read data valid |
| w_rd_ready | output | 1 | Wide read data ready |
| w_rd_data | input | WW | Wide read data |

## Verification
The bench fills memory with a marker pattern before the tests, so a lane written by mistake shows up as a changed marker byte, and a sparse or partial group that set all enables would overwrite the markers. Address-change and type-change sequences are counted at the wide port. A design that did not send the open group first would merge two wide words into one write or let a read overtake the write before it. Reads run at both wide latencies and from an unaligned start, where a misaligned lane queue returns sub-words shifted or in the wrong order. Further runs toggle every ready, block the narrow read channel until the lane queue fills, and offer a write command without data, which would expose dropped, repeated or early-accepted beats.

// File: rtl/mem_upsizer.sv
`timescale 1ns/1ps
module mem_upsizer #(
  parameter int NW  = 8,
  parameter int WW  = 32,
  parameter int AW  = 16,
  parameter int RDQ = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          n_cmd_valid,
  output logic                          n_cmd_ready,
  input  logic                          n_cmd_we,
  input  logic [AW-1:0]                 n_cmd_addr,
  input  logic                          n_cmd_last,
  input  logic                          n_wr_valid,
  output logic                          n_wr_ready,
  input  logic [NW-1:0]                 n_wr_data,
  input  logic [NW/8-1:0]               n_wr_be,
  output logic                          n_rd_valid,
  input  logic                          n_rd_ready,
  output logic [NW-1:0]                 n_rd_data,
  output logic                          w_cmd_valid,
  input  logic                          w_cmd_ready,
  output logic                          w_cmd_we,
  output logic [AW-$clog2(WW/NW)-1:0]   w_cmd_addr,
  output logic                          w_wr_valid,
  input  logic                          w_wr_ready,
  output logic [WW-1:0]                 w_wr_data,
  output logic [WW/8-1:0]               w_wr_be,
  input  logic                          w_rd_valid,
  output logic                          w_rd_ready,
  input  logic [WW-1:0]                 w_rd_data
);
  localparam int RATIO = WW / NW;
  localparam int SH    = $clog2(RATIO);
  localparam int WAW   = AW - SH;
  localparam int NB    = NW / 8;
  localparam int WB    = WW / 8;
  localparam int LW    = (SH > 0) ? SH : 1;
  localparam int CW    = $clog2(RATIO + 1);
  localparam int QW    = (RDQ > 1) ? $clog2(RDQ) : 1;

  if ((WW % NW) != 0 || (1 << SH) != RATIO || (NW % 8) != 0 || (1 << QW) != RDQ) begin : g_bad
    $error("mem_upsizer: width ratio must be a power-of-two integer, NW a byte multiple, RDQ a power of two");
  end

  if (RATIO == 1) begin : g_thru
    assign w_cmd_valid = n_cmd_valid;
    assign n_cmd_ready = w_cmd_ready;
    assign w_cmd_we    = n_cmd_we;
    assign w_cmd_addr  = n_cmd_addr;
    assign w_wr_valid  = n_wr_valid;
    assign n_wr_ready  = w_wr_ready;
    assign w_wr_data   = n_wr_data;
    assign w_wr_be     = n_wr_be;
    assign n_rd_valid  = w_rd_valid;
    assign w_rd_ready  = n_rd_ready;
    assign n_rd_data   = w_rd_data;
  end else begin : g_pack
    logic            p_val, p_close, p_we, cmd_done, dat_done;
    logic [WAW-1:0]  p_addr;
    logic [WW-1:0]   p_data;
    logic [WB-1:0]   p_be;
    logic [CW-1:0]   p_cnt;
    logic [LW-1:0]   lane_q [RDQ];
    logic            last_q [RDQ];
    logic [QW:0]     wp, rp;
    logic [WW-1:0]   bit_m;

    wire [WAW-1:0] in_waddr = n_cmd_addr[AW-1:SH];
    wire [LW-1:0]  in_lane  = n_cmd_addr[LW-1:0];
    wire [QW-1:0]  wi       = wp[QW-1:0];
    wire [QW-1:0]  ri       = rp[QW-1:0];
    wire q_empty  = (wp == rp);
    wire q_full   = (wp[QW] != rp[QW]) && (wi == ri);
    wire mismatch = p_val && ((in_waddr != p_addr) || (n_cmd_we != p_we));
    wire conflict = n_cmd_valid && !p_close && mismatch;

    assign n_cmd_ready = !p_close && !mismatch && (n_cmd_we ? n_wr_valid : !q_full);
    assign n_wr_ready  = n_cmd_valid && n_cmd_we && n_cmd_ready;

    wire            take      = n_cmd_valid && n_cmd_ready;
    wire [CW-1:0]   cnt_nx    = (p_val ? p_cnt : '0) + CW'(1);
    wire            close_now = take && (n_cmd_last || cnt_nx == CW'(RATIO));
    wire [WB-1:0]   lane_be   = WB'(n_wr_be) << (in_lane * NB);
    wire [WW-1:0]   lane_dat  = WW'(n_wr_data) << (in_lane * NW);

    always_comb begin
      for (int b = 0; b < WB; b++) bit_m[b*8 +: 8] = {8{lane_be[b]}};
    end

    wire [WW-1:0] mrg_data = ((p_val ? p_data : '0) & ~bit_m) | (lane_dat & bit_m);
    wire [WB-1:0] mrg_be   = (p_val ? p_be : '0) | lane_be;

    assign w_cmd_valid = p_close && !cmd_done;
    assign w_cmd_we    = p_we;
    assign w_cmd_addr  = p_addr;
    assign w_wr_valid  = p_close && p_we && !dat_done;
    assign w_wr_data   = p_data;
    assign w_wr_be     = p_be;

    wire cmd_hs = w_cmd_valid && w_cmd_ready;
    wire dat_hs = w_wr_valid && w_wr_ready;
    wire issued = p_close && (cmd_done || cmd_hs) && (!p_we || dat_done || dat_hs);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_val <= 1'b0; p_close <= 1'b0; p_we <= 1'b0;
        cmd_done <= 1'b0; dat_done <= 1'b0;
        p_addr <= '0; p_data <= '0; p_be <= '0; p_cnt <= '0;
      end else if (issued) begin
        p_val <= 1'b0; p_close <= 1'b0;
        cmd_done <= 1'b0; dat_done <= 1'b0;
      end else if (p_close) begin
        if (cmd_hs) cmd_done <= 1'b1;
        if (dat_hs) dat_done <= 1'b1;
      end else begin
        if (conflict) p_close <= 1'b1;
        if (take) begin
          p_val  <= 1'b1;
          p_we   <= n_cmd_we;
          p_addr <= in_waddr;
          p_cnt  <= cnt_nx;
          if (n_cmd_we) begin
            p_data <= mrg_data;
            p_be   <= mrg_be;
          end
          if (close_now) p_close <= 1'b1;
        end
      end
    end

    wire push = take && !n_cmd_we;
    wire pop  = n_rd_valid && n_rd_ready;

    always_ff @(posedge clk) begin
      if (push) begin
        lane_q[wi] <= in_lane;
        last_q[wi] <= close_now;
      end
      if (conflict && !p_we) last_q[wi - QW'(1)] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
      end
    end

    assign n_rd_valid = w_rd_valid && !q_empty;
    assign n_rd_data  = NW'(w_rd_data >> (lane_q[ri] * NW));
    assign w_rd_ready = pop && last_q[ri];

    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      w_cmd_valid && !w_cmd_ready |=> w_cmd_valid && $stable(w_cmd_addr) && $stable(w_cmd_we));
    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      w_wr_valid && !w_wr_ready |=> w_wr_valid && $stable(w_wr_data) && $stable(w_wr_be));
    p_flush_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      n_cmd_valid && n_cmd_ready && n_cmd_last |=> w_cmd_valid);
    p_no_take_while_issuing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      n_cmd_valid && n_cmd_ready |-> !w_cmd_valid);
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wp - rp) <= (QW+1)'(RDQ));
  end
endmodule

// File: tb/mem_upsizer_tb.sv
`timescale 1ns/1ps
module mem_upsizer_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n = 1'b0;

  logic        n_cmd_valid = 0, n_cmd_we = 0, n_cmd_last = 0;
  logic [15:0] n_cmd_addr = '0;
  logic        n_wr_valid = 0;
  logic [7:0]  n_wr_data = '0;
  logic [0:0]  n_wr_be = 1'b1;
  logic        n_rd_ready = 0;
  logic        n_cmd_ready, n_wr_ready, n_rd_valid;
  logic [7:0]  n_rd_data;
  logic        w_cmd_valid, w_cmd_we, w_wr_valid, w_rd_ready;
  logic [13:0] w_cmd_addr;
  logic [31:0] w_wr_data;
  logic [3:0]  w_wr_be;
  logic        w_cmd_ready = 0, w_wr_ready = 0, w_rd_valid = 0;
  logic [31:0] w_rd_data = '0;

  mem_upsizer #(.NW(8), .WW(32), .AW(16), .RDQ(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .n_cmd_valid(n_cmd_valid), .n_cmd_ready(n_cmd_ready), .n_cmd_we(n_cmd_we),
    .n_cmd_addr(n_cmd_addr), .n_cmd_last(n_cmd_last),
    .n_wr_valid(n_wr_valid), .n_wr_ready(n_wr_ready), .n_wr_data(n_wr_data), .n_wr_be(n_wr_be),
    .n_rd_valid(n_rd_valid), .n_rd_ready(n_rd_ready), .n_rd_data(n_rd_data),
    .w_cmd_valid(w_cmd_valid), .w_cmd_ready(w_cmd_ready), .w_cmd_we(w_cmd_we), .w_cmd_addr(w_cmd_addr),
    .w_wr_valid(w_wr_valid), .w_wr_ready(w_wr_ready), .w_wr_data(w_wr_data), .w_wr_be(w_wr_be),
    .w_rd_valid(w_rd_valid), .w_rd_ready(w_rd_ready), .w_rd_data(w_rd_data));

  logic        t_cv = 0, t_cwe = 0, t_cl = 0, t_wv = 0, t_rr = 0, t_wcr = 0, t_wwr = 0, t_wrv = 0;
  logic [15:0] t_ca = '0;
  logic [31:0] t_wd = '0, t_wrd = '0;
  logic [3:0]  t_be = '0;
  logic        t_ncr, t_nwr, t_nrv, t_wcv, t_wcwe, t_wwv, t_wrr;
  logic [31:0] t_nrd, t_wwd;
  logic [15:0] t_wca;
  logic [3:0]  t_wbe;

  mem_upsizer #(.NW(32), .WW(32), .AW(16), .RDQ(8)) u_thru (
    .clk(clk), .rst_n(rst_n),
    .n_cmd_valid(t_cv), .n_cmd_ready(t_ncr), .n_cmd_we(t_cwe), .n_cmd_addr(t_ca), .n_cmd_last(t_cl),
    .n_wr_valid(t_wv), .n_wr_ready(t_nwr), .n_wr_data(t_wd), .n_wr_be(t_be),
    .n_rd_valid(t_nrv), .n_rd_ready(t_rr), .n_rd_data(t_nrd),
    .w_cmd_valid(t_wcv), .w_cmd_ready(t_wcr), .w_cmd_we(t_wcwe), .w_cmd_addr(t_wca),
    .w_wr_valid(t_wwv), .w_wr_ready(t_wwr), .w_wr_data(t_wwd), .w_wr_be(t_wbe),
    .w_rd_valid(t_wrv), .w_rd_ready(t_wrr), .w_rd_data(t_wrd));

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [16];
  logic [31:0] cyc = 0;
  int lat = 0;
  logic bp = 0, hold = 0;
  int wwr_n = 0, wrd_n = 0, rl_n = 0;
  logic [7:0]  rlog [64];
  logic [3:0]  last_be = '0;
  logic        hs_c = 0, hs_w = 0, hs_r = 0, c_we = 0;
  logic [13:0] c_addr = '0, pc_a = '0;
  logic [31:0] w_d = '0, pd_d = '0;
  logic [3:0]  w_b = '0, pd_b = '0;
  logic        pc_v = 0, pd_v = 0;
  logic [13:0] rq_addr [16];
  logic [31:0] rq_time [16];
  int rq_hd = 0, rq_tl = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] = 32'hA5A5_A5A5;
      hs_c = 0; hs_w = 0; hs_r = 0;
    end else begin
      cyc = cyc + 1;
      if (hs_c) begin
        if (c_we) begin pc_v = 1; pc_a = c_addr; end
        else begin
          rq_addr[rq_tl % 16] = c_addr; rq_time[rq_tl % 16] = cyc + 32'(lat);
          rq_tl++; wrd_n++;
        end
      end
      if (hs_w) begin pd_v = 1; pd_d = w_d; pd_b = w_b; end
      if (pc_v && pd_v) begin
        for (int b = 0; b < 4; b++) if (pd_b[b]) mem[pc_a[3:0]][b*8 +: 8] = pd_d[b*8 +: 8];
        last_be = pd_b; wwr_n++; pc_v = 0; pd_v = 0;
      end
      if (hs_r) rq_hd++;
      w_cmd_ready = bp ? cyc[0] : 1'b1;
      w_wr_ready  = bp ? cyc[1] : 1'b1;
      n_rd_ready  = hold ? 1'b0 : (bp ? ~cyc[0] : 1'b1);
      if (rq_hd != rq_tl && cyc >= rq_time[rq_hd % 16]) begin
        w_rd_valid = 1; w_rd_data = mem[rq_addr[rq_hd % 16][3:0]];
      end else begin
        w_rd_valid = 0;
      end
      #1;
      hs_c = w_cmd_valid && w_cmd_ready; c_we = w_cmd_we; c_addr = w_cmd_addr;
      hs_w = w_wr_valid && w_wr_ready; w_d = w_wr_data; w_b = w_wr_be;
      hs_r = w_rd_valid && w_rd_ready;
      if (n_rd_valid && n_rd_ready) begin rlog[rl_n % 64] = n_rd_data; rl_n++; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ncmd(input bit we, input int addr, input logic [7:0] d, input bit last);
    @(negedge clk);
    n_cmd_valid = 1; n_cmd_we = we; n_cmd_addr = 16'(addr); n_cmd_last = last;
    n_wr_valid = we; n_wr_data = d; n_wr_be = 1'b1;
    #2;
    while (!n_cmd_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    n_cmd_valid = 0; n_wr_valid = 0; n_cmd_last = 0;
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic wait_resp(input int n);
    int t = 0;
    while (rl_n < n && t < 400) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 reset w_cmd_valid", 32'(w_cmd_valid), 0);
    chk("R3 reset w_wr_valid", 32'(w_wr_valid), 0);
    chk("R8 reset n_rd_valid", 32'(n_rd_valid), 0);
  endtask

  task automatic t_full_run();
    int w0 = wwr_n;
    ncmd(1, 0, 8'h11, 0); ncmd(1, 1, 8'h22, 0); ncmd(1, 2, 8'h33, 0); ncmd(1, 3, 8'h44, 0);
    settle();
    chk("R3 one wide write", 32'(wwr_n - w0), 1);
    chk("R2 packed word", mem[0], 32'h4433_2211);
    chk("R3 full enables", 32'(last_be), 32'hF);
  endtask

  task automatic t_last_flush();
    int w0 = wwr_n;
    ncmd(1, 4, 8'h51, 0); ncmd(1, 5, 8'h52, 0); ncmd(1, 6, 8'h53, 1);
    settle();
    chk("R4 one wide write", 32'(wwr_n - w0), 1);
    chk("R4 partial word", mem[1], 32'hA553_5251);
    chk("R4 enables", 32'(last_be), 32'h7);
  endtask

  task automatic t_addr_change();
    int w0 = wwr_n;
    ncmd(1, 8, 8'h61, 0); ncmd(1, 9, 8'h62, 0); ncmd(1, 10, 8'h63, 0);
    ncmd(1, 12, 8'h71, 0); ncmd(1, 13, 8'h72, 0); ncmd(1, 14, 8'h73, 0); ncmd(1, 15, 8'h74, 0);
    settle();
    chk("R5 two wide writes", 32'(wwr_n - w0), 2);
    chk("R5 first word", mem[2], 32'hA563_6261);
    chk("R5 second word", mem[3], 32'h7473_7271);
  endtask

  task automatic t_type_change();
    int w0 = wwr_n, r0 = wrd_n, l0 = rl_n;
    ncmd(1, 16, 8'h81, 0); ncmd(1, 17, 8'h82, 0);
    ncmd(0, 16, 0, 0); ncmd(0, 17, 0, 0); ncmd(0, 18, 0, 0); ncmd(0, 19, 0, 1);
    wait_resp(l0 + 4);
    chk("R6 write sent first", 32'(wwr_n - w0), 1);
    chk("R6 write word", mem[4], 32'hA5A5_8281);
    chk("R6 one wide read", 32'(wrd_n - r0), 1);
    chk("R6 resp0", 32'(rlog[l0 % 64]), 32'h81);
    chk("R6 resp1", 32'(rlog[(l0+1) % 64]), 32'h82);
    chk("R6 resp2", 32'(rlog[(l0+2) % 64]), 32'hA5);
    chk("R8 resp count", 32'(rl_n - l0), 4);
  endtask

  task automatic t_sparse();
    ncmd(1, 20, 8'h91, 0); ncmd(1, 22, 8'h92, 0); ncmd(1, 23, 8'h93, 1);
    settle();
    chk("R7 sparse word", mem[5], 32'h9392_A591);
    chk("R7 sparse enables", 32'(last_be), 32'hD);
  endtask

  task automatic t_read_aligned();
    int r0 = wrd_n, l0 = rl_n;
    logic [7:0] exp [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    for (int i = 0; i < 4; i++) ncmd(0, i, 0, i == 3);
    wait_resp(l0 + 4);
    chk("R8 one wide read", 32'(wrd_n - r0), 1);
    for (int i = 0; i < 4; i++) chk("R8 aligned lane", 32'(rlog[(l0+i) % 64]), 32'(exp[i]));
  endtask

  task automatic t_read_unaligned();
    int r0 = wrd_n, l0 = rl_n;
    logic [7:0] exp [5] = '{8'h52, 8'h53, 8'hA5, 8'h61, 8'h62};
    lat = 1;
    for (int i = 0; i < 5; i++) ncmd(0, 5 + i, 0, i == 4);
    wait_resp(l0 + 5);
    lat = 0;
    chk("R9 two wide reads", 32'(wrd_n - r0), 2);
    chk("R9 resp count", 32'(rl_n - l0), 5);
    for (int i = 0; i < 5; i++) chk("R9 unaligned lane", 32'(rlog[(l0+i) % 64]), 32'(exp[i]));
  endtask

  task automatic t_backpressure();
    int w0 = wwr_n, r0 = wrd_n, l0 = rl_n;
    logic [7:0] exp [4] = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
    bp = 1;
    for (int i = 0; i < 4; i++) ncmd(1, 24 + i, exp[i], 0);
    for (int i = 0; i < 4; i++) ncmd(0, 24 + i, 0, i == 3);
    wait_resp(l0 + 4);
    settle();
    bp = 0;
    chk("R10 one write under stall", 32'(wwr_n - w0), 1);
    chk("R10 one read under stall", 32'(wrd_n - r0), 1);
    chk("R10 word under stall", mem[6], 32'hC4C3_C2C1);
    chk("R10 resp count", 32'(rl_n - l0), 4);
    for (int i = 0; i < 4; i++) chk("R10 resp data", 32'(rlog[(l0+i) % 64]), 32'(exp[i]));
  endtask

  task automatic t_queue_full();
    int l0 = rl_n;
    logic [7:0] exp [9] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h51, 8'h52, 8'h53, 8'hA5, 8'h61};
    hold = 1;
    for (int i = 0; i < 8; i++) ncmd(0, i, 0, i == 7);
    @(negedge clk);
    n_cmd_valid = 1; n_cmd_we = 0; n_cmd_addr = 16'd8; n_cmd_last = 1;
    repeat (4) @(negedge clk);
    #2;
    chk("R12 read blocked when queue full", 32'(n_cmd_ready), 0);
    chk("R12 no responses while held", 32'(rl_n - l0), 0);
    hold = 0;
    @(negedge clk); #2;
    while (!n_cmd_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    n_cmd_valid = 0; n_cmd_last = 0;
    wait_resp(l0 + 9);
    chk("R12 resp count", 32'(rl_n - l0), 9);
    for (int i = 0; i < 9; i++) chk("R12 resp order", 32'(rlog[(l0+i) % 64]), 32'(exp[i]));
  endtask

  task automatic t_write_needs_data();
    int w0 = wwr_n;
    @(negedge clk);
    n_cmd_valid = 1; n_cmd_we = 1; n_cmd_addr = 16'd28; n_cmd_last = 1; n_wr_valid = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R11 cmd ready without data", 32'(n_cmd_ready), 0);
    chk("R11 data ready without data", 32'(n_wr_ready), 0);
    chk("R11 nothing sent", 32'(wwr_n - w0), 0);
    n_wr_valid = 1; n_wr_data = 8'hD1; n_wr_be = 1'b1;
    #1;
    chk("R11 cmd ready with data", 32'(n_cmd_ready), 1);
    chk("R11 data ready with data", 32'(n_wr_ready), 1);
    @(posedge clk); #1;
    n_cmd_valid = 0; n_wr_valid = 0; n_cmd_last = 0;
    settle();
    chk("R11 word written", mem[7], 32'hA5A5_A5D1);
  endtask

  task automatic t_passthrough();
    t_cv = 1; t_cwe = 1; t_ca = 16'h1234; t_wcr = 0;
    t_wv = 1; t_wd = 32'h0BAD_F00D; t_be = 4'h6; t_wwr = 1;
    t_wrv = 1; t_wrd = 32'hDEAD_BEEF; t_rr = 0;
    #1;
    chk("R1 cmd valid through", 32'(t_wcv), 1);
    chk("R1 cmd addr through", 32'(t_wca), 32'h1234);
    chk("R1 cmd ready back", 32'(t_ncr), 0);
    chk("R1 write data through", t_wwd, 32'h0BAD_F00D);
    chk("R1 enables through", 32'(t_wbe), 32'h6);
    chk("R1 read data through", t_nrd, 32'hDEAD_BEEF);
    chk("R1 read ready back low", 32'(t_wrr), 0);
    t_wcr = 1; t_rr = 1;
    #1;
    chk("R1 cmd ready back high", 32'(t_ncr), 1);
    chk("R1 read ready back high", 32'(t_wrr), 1);
    t_cv = 0; t_wv = 0; t_wrv = 0;
  endtask

  bit done = 0;
  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #2;
    t_reset();
    t_passthrough();
    t_full_run();
    t_last_flush();
    t_addr_change();
    t_type_change();
    t_sparse();
    t_read_aligned();
    t_read_unaligned();
    t_backpressure();
    t_queue_full();
    t_write_needs_data();
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule